// File: doc/BRIEF.md
# Ping-Pong Receive Store for a Bulk OUT Endpoint

This block is the receive-side packet store of one bulk OUT endpoint in a full-speed USB device controller. A decoder upstream presents each OUT token as a one-cycle strobe. It then delivers the data packet as a start strobe, a series of byte strobes and an end strobe with a CRC verdict. The block holds two packet slots that fill and drain in strict alternation. It decides the handshake for each OUT transaction and returns it one cycle after the end strobe.

Admission depends on a whole slot being free. The free-slot check is made when the token arrives. A slot that the processor has partly read still counts as occupied. While both slots hold packets, the host is held off with NAK. The processor drains the oldest packet one byte per read strobe. A read word carries the byte in its low eight bits and zeros above. The processor sees the length of the oldest stored packet. A level interrupt announces every packet that is stored, and the processor clears it by writing a one.

Top module: `bulk_out_pingpong`

## Requirements
- R1: Packets are stored into two slots in alternation and read back oldest first. A slot is released on the read of its last byte, and reading then moves on to the other slot.
- R2: `rd_count` shows the byte length of the oldest stored packet, and 0 when no packet is stored. It never exceeds MAX_PKT.
- R3: Each `rd_strobe` while a packet is stored returns that packet's next byte on `rd_data[7:0]` from the following cycle on, with all upper bits of `rd_data` zero.
- R4: An OUT token that finds the next slot free, followed by a packet with a good CRC and at most MAX_PKT bytes, gives a one-cycle `hs_ack` in the cycle after `rx_eop`. `hs_ack` and `hs_nak` are never high together.
- R5: An OUT token that arrives while both slots hold packets, including one that is partly read, gives a one-cycle `hs_nak` after `rx_eop`. The packet's bytes are dropped. Every later token is refused in the same way until the processor has released a slot.
- R6: `irq` rises in the cycle after a packet is stored and stays high until `irq_clr`. A store in the same cycle as `irq_clr` wins over the clear. If a packet is still stored when `irq` is cleared, `irq` rises again one cycle later.
- R7: A packet that ends with `rx_crc_ok` low is discarded. Its slot stays free, and the block gives no handshake and no interrupt for it.
- R8: A packet of more than MAX_PKT bytes is discarded in the same way as a bad CRC packet. A packet of exactly MAX_PKT bytes is stored.
- R9: A zero-length packet takes a slot, is acknowledged, raises `irq` and shows a count of 0. One read strobe returns 0 and releases the slot.
- R10: A read strobe while no packet is stored returns 0 and changes no other state.
- R11: After reset, all outputs are zero and both slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_out | input | 1 | OUT token addressed to this endpoint (strobe) |
| rx_sop | input | 1 | Start of the data packet (strobe) |
| rx_valid | input | 1 | `rx_byte` carries a data byte (strobe) |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of the data packet (strobe, never with `rx_valid`) |
| rx_crc_ok | input | 1 | CRC verdict, sampled with `rx_eop` |
| hs_ack | output | 1 | Send ACK (one cycle) |
| hs_nak | output | 1 | Send NAK (one cycle) |
| rd_strobe | input | 1 | Processor read of the data register |
| rd_data | output | RD_W (32) | Read word, byte in bits 7:0 |
| rd_count | output | clog2(MAX_PKT+1) (7) | Length of the oldest stored packet |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with MAX_PKT set to 8. This keeps the overflow case short: a nine-byte packet is enough to test R8. The other scenarios are also short, so the bench can run many fill, drain and refuse cycles. The slot storage is 16 bytes, so the exact-limit packet, the one-byte-too-long packet, the zero-length packet and NAK during a partial drain can each be reached in a few dozen cycles. Both slot indices are used as write and read slots several times.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int SLOTS = 2;
  typedef enum logic [1:0] {HS_NONE, HS_ACK, HS_NAK} hs_e;
endpackage

// File: rtl/bop_rx_ctrl.sv
// Token admission, byte placement, overflow tracking and handshake choice.
module bop_rx_ctrl #(
  parameter int MAX_PKT = 64,
  parameter int CW      = $clog2(MAX_PKT + 1),
  parameter int AW      = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  input  logic [1:0]    slot_valid,
  output logic          wr_en,
  output logic          wr_slot,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_byte,
  output logic          commit,
  output logic          commit_slot,
  output logic [CW-1:0] commit_len,
  output logic          hs_ack,
  output logic          hs_nak
);
  import bop_pkg::*;

  logic          wr_ptr_q, wr_ptr_n;
  logic          tok_q, tok_n;
  logic          adm_q, adm_n;
  logic          ovf_q, ovf_n;
  logic [CW-1:0] idx_q, idx_n;
  hs_e           hs_q, hs_n;
  logic          full;
  logic          take;

  assign full        = (idx_q == CW'(MAX_PKT));
  assign take        = rx_valid & tok_q & adm_q;
  assign wr_en       = take & ~full;
  assign wr_slot     = wr_ptr_q;
  assign wr_addr     = idx_q[AW-1:0];
  assign wr_byte     = rx_byte;
  assign commit      = rx_eop & tok_q & adm_q & rx_crc_ok & ~ovf_q;
  assign commit_slot = wr_ptr_q;
  assign commit_len  = idx_q;
  assign hs_ack      = (hs_q == HS_ACK);
  assign hs_nak      = (hs_q == HS_NAK);

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    tok_n    = tok_q;
    adm_n    = adm_q;
    ovf_n    = ovf_q;
    idx_n    = idx_q;
    hs_n     = HS_NONE;
    if (tok_out) begin
      tok_n = 1'b1;
      adm_n = ~slot_valid[wr_ptr_q];
    end
    if (rx_sop) begin
      idx_n = '0;
      ovf_n = 1'b0;
    end
    if (take) begin
      if (full) ovf_n = 1'b1;
      else      idx_n = idx_q + CW'(1);
    end
    if (rx_eop && tok_q) begin
      tok_n = 1'b0;
      adm_n = 1'b0;
      if (!adm_q) begin
        hs_n = HS_NAK;
      end else if (commit) begin
        hs_n     = HS_ACK;
        wr_ptr_n = ~wr_ptr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= 1'b0;
      tok_q    <= 1'b0;
      adm_q    <= 1'b0;
      ovf_q    <= 1'b0;
      idx_q    <= '0;
      hs_q     <= HS_NONE;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      tok_q    <= tok_n;
      adm_q    <= adm_n;
      ovf_q    <= ovf_n;
      idx_q    <= idx_n;
      hs_q     <= hs_n;
    end
  end
endmodule

// File: rtl/bop_slot_bank.sv
// Two packet slots: byte storage, stored length and occupancy per slot.
module bop_slot_bank #(
  parameter int MAX_PKT = 64,
  parameter int CW      = $clog2(MAX_PKT + 1),
  parameter int AW      = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_slot,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic          commit,
  input  logic          commit_slot,
  input  logic [CW-1:0] commit_len,
  input  logic          free,
  input  logic          free_slot,
  input  logic          rd_slot,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    slot_valid,
  output logic [CW-1:0] rd_len,
  output logic [7:0]    rd_byte
);
  import bop_pkg::*;

  logic [CW-1:0] len_arr  [SLOTS];
  logic [7:0]    byte_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic          valid_q, valid_n;
    logic [CW-1:0] len_q, len_n;
    logic [7:0]    mem_q [MAX_PKT];
    logic          mem_we;
    logic          sel_commit, sel_free;

    assign sel_commit = commit & (commit_slot == 1'(s));
    assign sel_free   = free   & (free_slot   == 1'(s));
    assign mem_we     = wr_en  & (wr_slot     == 1'(s));

    always_comb begin
      valid_n = valid_q;
      len_n   = len_q;
      if (sel_commit) begin
        valid_n = 1'b1;
        len_n   = commit_len;
      end else if (sel_free) begin
        valid_n = 1'b0;
        len_n   = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        len_q   <= '0;
      end else begin
        valid_q <= valid_n;
        len_q   <= len_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < MAX_PKT; b++) mem_q[b] <= '0;
      end else if (mem_we) begin
        mem_q[wr_addr] <= wr_byte;
      end
    end

    assign slot_valid[s] = valid_q;
    assign len_arr[s]    = len_q;
    assign byte_arr[s]   = mem_q[rd_addr];
  end

  assign rd_len  = len_arr[rd_slot];
  assign rd_byte = byte_arr[rd_slot];
endmodule

// File: rtl/bop_rd_port.sv
// Processor-side drain: read pointer, byte index, data register, slot release.
module bop_rd_port #(
  parameter int MAX_PKT = 64,
  parameter int RD_W    = 32,
  parameter int CW      = $clog2(MAX_PKT + 1),
  parameter int AW      = $clog2(MAX_PKT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strobe,
  input  logic [1:0]      slot_valid,
  input  logic [CW-1:0]   rd_len,
  input  logic [7:0]      rd_byte,
  output logic            rd_slot,
  output logic [AW-1:0]   rd_addr,
  output logic            free,
  output logic            free_slot,
  output logic [RD_W-1:0] rd_data
);
  logic          rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] ridx_q, ridx_n;
  logic [7:0]    data_q, data_n;
  logic          have;
  logic          last;

  assign have      = slot_valid[rd_ptr_q];
  assign last      = (rd_len == '0) || ((ridx_q + CW'(1)) == rd_len);
  assign free      = rd_strobe & have & last;
  assign free_slot = rd_ptr_q;
  assign rd_slot   = rd_ptr_q;
  assign rd_addr   = ridx_q[AW-1:0];
  assign rd_data   = RD_W'(data_q);

  always_comb begin
    rd_ptr_n = rd_ptr_q;
    ridx_n   = ridx_q;
    data_n   = data_q;
    if (rd_strobe) begin
      data_n = (have && rd_len != '0) ? rd_byte : 8'h00;
      if (have) begin
        if (last) begin
          ridx_n   = '0;
          rd_ptr_n = ~rd_ptr_q;
        end else begin
          ridx_n = ridx_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= 1'b0;
      ridx_q   <= '0;
      data_q   <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_n;
      ridx_q   <= ridx_n;
      data_q   <= data_n;
    end
  end
endmodule

// File: rtl/bulk_out_pingpong.sv
module bulk_out_pingpong #(
  parameter int MAX_PKT = 64,
  parameter int RD_W    = 32,
  localparam int CW     = $clog2(MAX_PKT + 1),
  localparam int AW     = $clog2(MAX_PKT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_out,
  input  logic            rx_sop,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_eop,
  input  logic            rx_crc_ok,
  output logic            hs_ack,
  output logic            hs_nak,
  input  logic            rd_strobe,
  output logic [RD_W-1:0] rd_data,
  output logic [CW-1:0]   rd_count,
  input  logic            irq_clr,
  output logic            irq
);
  logic          wr_en, wr_slot;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_byte;
  logic          commit, commit_slot;
  logic [CW-1:0] commit_len;
  logic          free, free_slot;
  logic          rd_slot;
  logic [AW-1:0] rd_addr;
  logic [1:0]    slot_valid;
  logic [CW-1:0] rd_len;
  logic [7:0]    rd_byte;
  logic          irq_q, irq_n;

  bop_rx_ctrl #(.MAX_PKT(MAX_PKT), .CW(CW), .AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_sop(rx_sop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rx_crc_ok(rx_crc_ok), .slot_valid(slot_valid), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .commit(commit), .commit_slot(commit_slot), .commit_len(commit_len),
    .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  bop_slot_bank #(.MAX_PKT(MAX_PKT), .CW(CW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_addr(wr_addr), .wr_byte(wr_byte), .commit(commit),
    .commit_slot(commit_slot), .commit_len(commit_len), .free(free),
    .free_slot(free_slot), .rd_slot(rd_slot), .rd_addr(rd_addr),
    .slot_valid(slot_valid), .rd_len(rd_len), .rd_byte(rd_byte)
  );

  bop_rd_port #(.MAX_PKT(MAX_PKT), .RD_W(RD_W), .CW(CW), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .slot_valid(slot_valid),
    .rd_len(rd_len), .rd_byte(rd_byte), .rd_slot(rd_slot), .rd_addr(rd_addr),
    .free(free), .free_slot(free_slot), .rd_data(rd_data)
  );

  // Interrupt: a new store wins over the clear; an idle flag is re-raised
  // while any slot still holds a packet.
  always_comb begin
    irq_n = irq_q;
    if (commit)                      irq_n = 1'b1;
    else if (irq_clr)                irq_n = 1'b0;
    else if (!irq_q && |slot_valid)  irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq      = irq_q;
  assign rd_count = rd_len;
endmodule

// File: rtl/bop_checker.sv
module bop_checker #(
  parameter int MAX_PKT = 64,
  parameter int CW      = $clog2(MAX_PKT + 1),
  parameter int RD_W    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_eop,
  input logic            rx_crc_ok,
  input logic            hs_ack,
  input logic            hs_nak,
  input logic            rd_strobe,
  input logic [RD_W-1:0] rd_data,
  input logic [CW-1:0]   rd_count,
  input logic            irq_clr,
  input logic            irq
);
  p_ack_nak_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));

  p_ack_after_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> $past(rx_eop));

  p_nak_after_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> $past(rx_eop));

  p_ack_sets_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> irq);

  p_clear_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !rx_eop) |=> !irq);

  p_bad_crc_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !rx_crc_ok) |=> !hs_ack);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CW'(MAX_PKT));

  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_count == '0) |=> (rd_data == '0));
endmodule

bind bulk_out_pingpong bop_checker #(.MAX_PKT(MAX_PKT), .CW(CW), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
  .hs_ack(hs_ack), .hs_nak(hs_nak), .rd_strobe(rd_strobe), .rd_data(rd_data),
  .rd_count(rd_count), .irq_clr(irq_clr), .irq(irq)
);

// File: tb/tb_bulk_out_pingpong.sv
`timescale 1ns/1ps
module tb_bulk_out_pingpong;
  localparam int MAXP = 8;
  localparam int RDW  = 32;
  localparam int CWT  = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_out = 0, rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_crc_ok = 0;
  logic [7:0] rx_byte = 0;
  logic rd_strobe = 0, irq_clr = 0;
  logic hs_ack, hs_nak, irq;
  logic [RDW-1:0] rd_data;
  logic [CWT-1:0] rd_count;

  always #4 clk = ~clk;

  bulk_out_pingpong #(.MAX_PKT(MAXP), .RD_W(RDW)) dut (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_sop(rx_sop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rx_crc_ok(rx_crc_ok), .hs_ack(hs_ack), .hs_nak(hs_nak),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_count(rd_count),
    .irq_clr(irq_clr), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_cur[$];
  logic [7:0] m_dat[$];
  int         m_len[$];
  int         m_pos, pre;
  bit         m_tok, m_adm, m_ovf, m_commit;
  bit         e_ack, e_nak, e_irq;
  logic [7:0] e_data;
  int         e_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur.delete(); m_dat.delete(); m_len.delete();
      m_pos = 0; m_tok = 0; m_adm = 0; m_ovf = 0;
      e_ack = 0; e_nak = 0; e_irq = 0; e_data = 0; e_cnt = 0;
    end else begin
      pre = m_len.size();
      e_ack = 0; e_nak = 0; m_commit = 0;
      if (tok_out) begin m_tok = 1; m_adm = (pre < 2); end
      if (rx_sop) begin m_cur.delete(); m_ovf = 0; end
      if (rx_valid && m_tok && m_adm) begin
        if (m_cur.size() == MAXP) m_ovf = 1;
        else m_cur.push_back(rx_byte);
      end
      if (rx_eop && m_tok) begin
        if (!m_adm) e_nak = 1;
        else if (rx_crc_ok && !m_ovf) begin e_ack = 1; m_commit = 1; end
        m_tok = 0; m_adm = 0;
      end
      if (rd_strobe) begin
        if (pre > 0) begin
          if (m_len[0] == 0) begin
            e_data = 0; void'(m_len.pop_front());
          end else begin
            e_data = m_dat.pop_front(); m_pos++;
            if (m_pos == m_len[0]) begin void'(m_len.pop_front()); m_pos = 0; end
          end
        end else e_data = 0;
      end
      if (m_commit) begin
        m_len.push_back(m_cur.size());
        foreach (m_cur[i]) m_dat.push_back(m_cur[i]);
      end
      if (m_commit) e_irq = 1;
      else if (irq_clr) e_irq = 0;
      else if (!e_irq && pre > 0) e_irq = 1;
      e_cnt = (m_len.size() > 0) ? m_len[0] : 0;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "hs_ack", hs_ack, e_ack);
      chk("R5", "hs_nak", hs_nak, e_nak);
      chk("R6", "irq", irq, e_irq);
      chk("R3", "rd_data", rd_data, {24'h0, e_data});
      chk("R2", "rd_count", rd_count, e_cnt);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    tok_out = 0; rx_sop = 0; rx_valid = 0; rx_eop = 0; rx_crc_ok = 0;
    rd_strobe = 0; irq_clr = 0;
  endtask

  bit last_ack, last_nak;

  task automatic send_pkt(input int n, input bit crc, input int seed);
    @(negedge clk); idle(); tok_out = 1;
    @(negedge clk); idle(); rx_sop = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle(); rx_valid = 1; rx_byte = 8'(seed + i);
    end
    @(negedge clk); idle(); rx_eop = 1; rx_crc_ok = crc;
    @(negedge clk); idle();
    last_ack = hs_ack; last_nak = hs_nak;
  endtask

  task automatic rd_one();
    @(negedge clk); idle(); rd_strobe = 1;
    @(negedge clk); idle();
  endtask

  task automatic clr_irq();
    @(negedge clk); idle(); irq_clr = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "rd_data reset", rd_data, 0);
    chk("R11", "rd_count reset", rd_count, 0);
    chk("R11", "irq reset", irq, 0);
    chk("R11", "handshake reset", {hs_ack, hs_nak}, 0);

    // R4 / R6 / R2: first packet
    send_pkt(3, 1, 8'h10);
    chk("R4", "ack first", last_ack, 1);
    chk("R6", "irq after store", irq, 1);
    chk("R2", "count first", rd_count, 3);

    // R1: second slot, oldest still shown
    send_pkt(5, 1, 8'h40);
    chk("R1", "ack second slot", last_ack, 1);
    chk("R1", "oldest first count", rd_count, 3);

    // R3: first byte read
    rd_one();
    chk("R3", "first byte", rd_data, 32'h10);

    // R5: partly drained slot still occupied
    send_pkt(2, 1, 8'h70);
    chk("R5", "nak partial drain", last_nak, 1);
    send_pkt(2, 1, 8'h70);
    chk("R5", "nak persists", last_nak, 1);

    rd_one(); rd_one();
    chk("R3", "third byte", rd_data, 32'h12);
    chk("R1", "next packet count", rd_count, 5);
    send_pkt(4, 1, 8'h80);
    chk("R5", "ack after free", last_ack, 1);

    // R6: clear with packets held re-raises
    @(negedge clk); idle(); irq_clr = 1;
    @(negedge clk); idle();
    chk("R6", "irq cleared", irq, 0);
    @(negedge clk);
    chk("R6", "irq re-raised", irq, 1);

    for (int i = 0; i < 9; i++) rd_one();
    chk("R1", "drained all", rd_count, 0);
    clr_irq();
    @(negedge clk);
    chk("R6", "irq stays low when empty", irq, 0);

    // R10: empty read
    rd_one();
    chk("R10", "empty read data", rd_data, 0);
    chk("R10", "empty read count", rd_count, 0);

    // R7: bad CRC
    send_pkt(3, 0, 8'h20);
    chk("R7", "no handshake on bad crc", {last_ack, last_nak}, 0);
    @(negedge clk);
    chk("R7", "no irq on bad crc", irq, 0);
    chk("R7", "slot free after bad crc", rd_count, 0);

    // R8: overflow and exact limit
    send_pkt(MAXP + 1, 1, 8'h30);
    chk("R8", "no handshake on overflow", {last_ack, last_nak}, 0);
    chk("R8", "no count on overflow", rd_count, 0);
    send_pkt(MAXP, 1, 8'h50);
    chk("R8", "exact limit stored", last_ack, 1);
    chk("R8", "exact limit count", rd_count, MAXP);
    for (int i = 0; i < MAXP; i++) rd_one();
    chk("R8", "last byte at limit", rd_data, 32'h57);
    clr_irq();

    // R9: zero-length packet
    send_pkt(0, 1, 0);
    chk("R9", "zlp ack", last_ack, 1);
    chk("R9", "zlp irq", irq, 1);
    chk("R9", "zlp count", rd_count, 0);
    send_pkt(2, 1, 8'h60);
    rd_one();
    chk("R9", "zlp read zero", rd_data, 0);
    chk("R9", "zlp freed", rd_count, 2);
    rd_one(); rd_one();
    chk("R1", "after zlp", rd_data, 32'h61);
    clr_irq();

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule